// File: doc/BRIEF.md
# Interrupt Request Register Block

This block is the request stage of a vectored interrupt controller. It takes a vector of hardware interrupt lines and merges each line with a bit that software can raise or drop. Each merged line is then gated by its own enable bit, and the gated lines are ORed into one request toward the processor. Software reaches the block through a small word-addressed register bus. Through that bus it can read the unmasked input state, drive the software bits directly or through write-only set and clear aliases, program the per-line enables, and hold the base address of the vector table.

A parameter mask says which interrupt lines are built. A line left out of the mask has no storage. Its status bit, software bit and enable bit all read as zero, and writes to them are ignored. Reads return data in the same cycle as the read strobe. Writes take effect at the clock edge on which the write strobe is sampled.

Top module: `irq_regblock`

## Requirements
- R1: After a synchronous reset the software interrupt, enable and vector base registers all read 0, and `irq_req` is 0 while `irq_in` is 0.
- R2: A read at word offset 36 returns `irq_in` ANDed with the line mask, in bit positions 0 to NUM_LINES-1, with upper bits 0. Writes to offset 36 change no register.
- R3: For a line whose mask bit is 0, the status, software and enable bits always read 0, whatever is written or driven on `irq_in`.
- R4: Offset 37 is the software interrupt register. A write loads bits `bus_wdata[NUM_LINES-1:0]` for the built lines, and a read returns them.
- R5: A write at offset 38 sets each built software bit whose write data bit is 1. Bits written 0 keep their value. A read at 38 returns 0.
- R6: A write at offset 39 clears each software bit whose write data bit is 1. Bits written 0 keep their value. A read at 39 returns 0.
- R7: Offset 43 is the per-line enable register. It is read/write, with bit i enabling line i.
- R8: `irq_req` is 1 exactly when some built line i has (`irq_in[i]` OR software bit i) AND enable bit i. It follows `irq_in` in the same cycle and follows register writes from the next cycle.
- R9: Offset 42 holds the vector table base. It is read/write over DATA_W bits, but bits 1:0 always read 0.
- R10: Reads of any offset other than 36, 37, 38, 39, 42 and 43 (including 40 and 41) return 0. Writes to them change no register.
- R11: `bus_rdata` is 0 in any cycle where `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe for the current cycle |
| bus_wr | input | 1 | Write strobe, applied at the clock edge |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of `bus_rd` |
| irq_in | input | NUM_LINES | Hardware interrupt lines, active high |
| irq_req | output | 1 | Combined enabled request toward the processor |

## Verification
The bench drives lines that are left out of the mask, both on `irq_in` and through all-ones writes to the software and enable registers. A design that let such a line through would show a nonzero status bit or a spurious `irq_req`. Set and clear writes are given data patterns that are mostly zeros, so a design that treated them as plain loads would wipe bits that should have been kept. It also reads the set and clear aliases and the unmapped offsets 40 and 41 right after writing them, which catches a leaked register value or a write that landed in the wrong place. Vector base writes with the low bits set catch a missing alignment clear. Throughout the run `irq_req` is compared against a model built from the inputs, which exposes a missing enable gate or a missing merge of software and hardware bits.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

    // Word offsets decoded by this block
    localparam int OFS_RAW   = 36;
    localparam int OFS_SW    = 37;
    localparam int OFS_SET   = 38;
    localparam int OFS_CLR   = 39;
    localparam int OFS_VBASE = 42;
    localparam int OFS_EN    = 43;

    // Number of low address bits forced to zero in the vector base
    localparam int VBASE_ALIGN_BITS = 2;

    // One-hot selection of the register targeted by an access
    typedef struct packed {
        logic raw;
        logic sw;
        logic set;
        logic clr;
        logic vbase;
        logic en;
    } reg_sel_t;

    // Write strobes handed to the register stores
    typedef struct packed {
        logic sw_load;
        logic sw_set;
        logic sw_clr;
        logic en_load;
        logic vb_load;
    } wr_strobe_t;

    function automatic logic [31:0] align_clear(input logic [31:0] v);
        logic [31:0] r;
        r = v;
        r[VBASE_ALIGN_BITS-1:0] = '0;
        return r;
    endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_regs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel,
    output logic              hit
);
    always_comb begin
        sel       = '0;
        sel.raw   = (int'(addr) == OFS_RAW);
        sel.sw    = (int'(addr) == OFS_SW);
        sel.set   = (int'(addr) == OFS_SET);
        sel.clr   = (int'(addr) == OFS_CLR);
        sel.vbase = (int'(addr) == OFS_VBASE);
        sel.en    = (int'(addr) == OFS_EN);
    end

    assign hit = |sel;
endmodule

// File: rtl/irq_linereg.sv
module irq_linereg #(
    parameter int             N     = 16,
    parameter logic [N-1:0]   MASK  = '1,
    parameter bit             ALIAS = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_load,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] q
);
    localparam bit USE_ALIAS = ALIAS;

    for (genvar i = 0; i < N; i++) begin : g_line
        if (MASK[i]) begin : g_live
            logic bit_q;
            logic alias_hit;

            assign alias_hit = USE_ALIAS && (wr_set || wr_clr);

            always_ff @(posedge clk) begin
                if (rst) begin
                    bit_q <= 1'b0;
                end else if (USE_ALIAS && wr_clr && wdata[i]) begin
                    bit_q <= 1'b0;
                end else if (USE_ALIAS && wr_set && wdata[i]) begin
                    bit_q <= 1'b1;
                end else if (wr_load && !alias_hit) begin
                    bit_q <= wdata[i];
                end
            end

            assign q[i] = bit_q;
        end else begin : g_absent
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
    parameter int           N    = 16,
    parameter logic [N-1:0] MASK = '1
) (
    input  logic [N-1:0] hw,
    input  logic [N-1:0] sw,
    input  logic [N-1:0] en,
    output logic [N-1:0] raw,
    output logic         req
);
    logic [N-1:0] merged;

    assign raw    = hw & MASK;
    assign merged = (raw | sw) & en;
    assign req    = |merged;
endmodule

// File: rtl/irq_regblock.sv
module irq_regblock
    import irq_regs_pkg::*;
#(
    parameter int                     NUM_LINES = 16,
    parameter int                     DATA_W    = 32,
    parameter int                     ADDR_W    = 6,
    parameter logic [NUM_LINES-1:0]   LINE_MASK = 16'h7FF7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic                 irq_req
);
    localparam int N = NUM_LINES;

    reg_sel_t            sel;
    logic                sel_hit;
    wr_strobe_t          stb;
    logic [N-1:0]        wlines;
    logic [N-1:0]        sw_q;
    logic [N-1:0]        en_q;
    logic [N-1:0]        raw_q;
    logic [DATA_W-1:0]   vbase_q;
    logic [DATA_W-1:0]   rd_mux;

    irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .hit  (sel_hit)
    );

    always_comb begin
        stb         = '0;
        stb.sw_load = bus_wr && sel.sw;
        stb.sw_set  = bus_wr && sel.set;
        stb.sw_clr  = bus_wr && sel.clr;
        stb.en_load = bus_wr && sel.en;
        stb.vb_load = bus_wr && sel.vbase;
    end

    assign wlines = bus_wdata[N-1:0];

    irq_linereg #(.N(N), .MASK(LINE_MASK), .ALIAS(1'b1)) u_sw (
        .clk     (clk),
        .rst     (rst),
        .wr_load (stb.sw_load),
        .wr_set  (stb.sw_set),
        .wr_clr  (stb.sw_clr),
        .wdata   (wlines),
        .q       (sw_q)
    );

    irq_linereg #(.N(N), .MASK(LINE_MASK), .ALIAS(1'b0)) u_en (
        .clk     (clk),
        .rst     (rst),
        .wr_load (stb.en_load),
        .wr_set  (1'b0),
        .wr_clr  (1'b0),
        .wdata   (wlines),
        .q       (en_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vbase_q <= '0;
        end else if (stb.vb_load) begin
            vbase_q <= DATA_W'(align_clear(32'(bus_wdata)));
        end
    end

    irq_req_gate #(.N(N), .MASK(LINE_MASK)) u_gate (
        .hw  (irq_in),
        .sw  (sw_q),
        .en  (en_q),
        .raw (raw_q),
        .req (irq_req)
    );

    always_comb begin
        rd_mux = '0;
        if (sel_hit) begin
            unique case (1'b1)
                sel.raw:   rd_mux = DATA_W'(raw_q);
                sel.sw:    rd_mux = DATA_W'(sw_q);
                sel.en:    rd_mux = DATA_W'(en_q);
                sel.vbase: rd_mux = vbase_q;
                default:   rd_mux = '0;
            endcase
        end
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/irq_regblock_chk.sv
module irq_regblock_chk #(
    parameter int                   NUM_LINES = 16,
    parameter int                   DATA_W    = 32,
    parameter int                   ADDR_W    = 6,
    parameter logic [NUM_LINES-1:0] LINE_MASK = '1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [NUM_LINES-1:0] sw_q,
    input logic [NUM_LINES-1:0] en_q
);
    logic mapped;
    assign mapped = (int'(bus_addr) inside {36, 37, 38, 39, 42, 43});

    // R1: registers clear in the cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (sw_q == '0 && en_q == '0));

    // R3: absent lines never hold state
    a_r3_absent_lines: assert property (@(posedge clk) disable iff (rst)
        ((sw_q & ~LINE_MASK) == '0) && ((en_q & ~LINE_MASK) == '0));

    // R5: set alias raises every written-one built bit
    a_r5_set_effect: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && int'(bus_addr) == 38) |=>
        ((sw_q & $past(bus_wdata[NUM_LINES-1:0] & LINE_MASK)) ==
         $past(bus_wdata[NUM_LINES-1:0] & LINE_MASK)));

    // R6: clear alias drops every written-one bit
    a_r6_clr_effect: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && int'(bus_addr) == 39) |=>
        ((sw_q & $past(bus_wdata[NUM_LINES-1:0])) == '0));

    // R5, R6: alias writes leave written-zero bits alone
    a_r6_alias_keep: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (int'(bus_addr) == 38 || int'(bus_addr) == 39)) |=>
        ((sw_q & ~$past(bus_wdata[NUM_LINES-1:0])) ==
         ($past(sw_q) & ~$past(bus_wdata[NUM_LINES-1:0]))));

    // R9: vector base reads are word aligned
    a_r9_vbase_align: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && int'(bus_addr) == 42) |-> (bus_rdata[1:0] == 2'b00));

    // R10: unmapped offsets read zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !mapped) |-> (bus_rdata == '0));

    // R10: writes to unmapped offsets leave software and enable bits alone
    a_r10_unmapped_wr: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !mapped) |=> ($stable(sw_q) && $stable(en_q)));

    // R11: idle bus returns zero
    a_r11_idle_rdata: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));
endmodule

bind irq_regblock irq_regblock_chk #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .LINE_MASK (LINE_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sw_q      (sw_q),
    .en_q      (en_q)
);

// File: tb/irq_regblock_bench.sv
module irq_regblock_bench;
    localparam int          NL   = 16;
    localparam int          DW   = 32;
    localparam int          AW   = 6;
    localparam logic [15:0] MASK = 16'h7FF7;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_rd, bus_wr;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic [NL-1:0] irq_in;
    logic          irq_req;

    int total = 0;
    int bad   = 0;

    logic [NL-1:0] m_sw, m_en;
    logic [DW-1:0] m_vb;

    always #4 clk = ~clk;

    irq_regblock #(.NUM_LINES(NL), .DATA_W(DW), .ADDR_W(AW), .LINE_MASK(MASK)) u_irq_regblock (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_req(irq_req)
    );

    function automatic logic [DW-1:0] exp_read(input int a);
        case (a)
            36:      return DW'(irq_in & MASK);
            37:      return DW'(m_sw);
            42:      return m_vb;
            43:      return DW'(m_en);
            default: return '0;
        endcase
    endfunction

    function automatic logic exp_req();
        return |(((irq_in & MASK) | m_sw) & m_en);
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic model_write(input int a, input logic [DW-1:0] d);
        case (a)
            37: m_sw = d[NL-1:0] & MASK;
            38: m_sw = m_sw | (d[NL-1:0] & MASK);
            39: m_sw = m_sw & ~d[NL-1:0];
            42: m_vb = {d[DW-1:2], 2'b00};
            43: m_en = d[NL-1:0] & MASK;
            default: ;
        endcase
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_read(input int a, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = AW'(a);
        #1;
        check(tag, bus_rdata, exp_read(a));
        check("R8 irq_req", DW'(irq_req), DW'(exp_req()));
        #1;
        bus_rd = 1'b0;
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; irq_in = '0;
        m_sw = '0; m_en = '0; m_vb = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        do_read(37, "R1 sw after reset");
        do_read(43, "R1 en after reset");
        do_read(42, "R1 vbase after reset");
        check("R1 irq_req after reset", DW'(irq_req), '0);

        // R11 idle bus
        @(negedge clk); bus_addr = AW'(42); #1;
        check("R11 rdata idle", bus_rdata, '0);

        // R4 / R3 direct load, absent lines stay zero
        do_write(37, 32'hFFFF_FFFF);
        do_read(37, "R4 R3 sw load all ones");
        do_write(43, 32'h0000_FFFF);
        do_read(43, "R7 R3 en load all ones");

        // R5 set with zeros keeps state, R6 clear of few bits
        do_write(37, 32'h0000_0000);
        do_write(38, 32'h0000_0101);
        do_read(37, "R5 set two bits");
        do_write(38, 32'h0000_0000);
        do_read(37, "R5 set zero no effect");
        do_write(39, 32'h0000_0001);
        do_read(37, "R6 clear one bit");
        do_read(38, "R5 set reads zero");
        do_read(39, "R6 clr reads zero");

        // R3 absent line on irq_in does not reach status or request
        do_write(37, 32'h0);
        irq_in = 16'h8008;
        do_read(36, "R3 R2 absent raw");
        check("R3 absent no req", DW'(irq_req), '0);
        irq_in = 16'h0010;
        do_read(36, "R2 raw live line");
        check("R8 hw enabled req", DW'(irq_req), 32'd1);
        do_write(43, 32'h0000_0000);
        do_read(36, "R8 disabled");

        // R9 alignment
        do_write(42, 32'hDEAD_BEEF);
        do_read(42, "R9 vbase aligned");

        // R10 unmapped writes ignored
        do_write(40, 32'hFFFF_FFFF);
        do_write(41, 32'hFFFF_FFFF);
        do_write(36, 32'hFFFF_FFFF);
        do_read(40, "R10 offset 40 zero");
        do_read(41, "R10 offset 41 zero");
        do_read(0,  "R10 offset 0 zero");
        do_read(63, "R10 offset 63 zero");
        do_read(37, "R10 sw unchanged");
        do_read(43, "R10 en unchanged");
        do_read(42, "R10 vbase unchanged");

        // Constrained random mix
        void'($urandom(32'h1234_5678));
        for (int k = 0; k < 600; k++) begin
            int op;
            int a;
            logic [DW-1:0] d;
            op = int'($urandom_range(0, 9));
            a  = (op < 8) ? int'($urandom_range(36, 43)) : int'($urandom_range(0, 63));
            d  = $urandom();
            if ($urandom_range(0, 3) == 0) d = d & 32'h0000_0421;
            if (op < 4) begin
                do_write(a, d);
            end else if (op < 8) begin
                do_read(a, "R2 R4 R7 R9 R10 random read");
            end else if (op == 8) begin
                irq_in = NL'($urandom());
                #1;
                check("R8 random irq_req", DW'(irq_req), DW'(exp_req()));
            end else begin
                do_read(a, "R10 random offset");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule